// File: doc/BRIEF.md
# Protected System Clock Source and Divider Control

This block produces the system clock of a chip from one of two sources. The first is a fast PLL output (`fout`) that can be slowed by 1, 2, 4 or 8. The second is a slow low-power clock. One power-control word sets the source, the divide code and the enable bits of the two oscillators. A separate key register locks that word. Writes to the power-control word take effect only while the key register holds 0x96. The key is not cleared by a later write, so software must write any other value to lock the word again.

Three rules protect the running clock. A change of source is accepted only when both oscillators are enabled, the key is open and the target oscillator reports itself stable. A request to disable the fast oscillator is ignored while the fast source is selected.

Both clock changes are glitch-free. A divide change is picked up only at the wrap of a free-running divide-by-8 counter, at a point where every candidate clock is low. A source change hands over through a pair of falling-edge synchronisers: the old clock is released first, and the new clock is engaged afterwards on its own falling edge.

Top module: `sysclk_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the power-control word reads 0x06 and the key register reads 0x00. The fast oscillator enable output is 1, the slow one is 0, and `sys_clk` follows `fout` undivided.
- R2: Bits 7:6 of the power-control word (address 0) set the fast divide: 00 gives fout/1, 01 gives fout/2, 10 gives fout/4 and 11 gives fout/8.
- R3: While the slow source is selected, the divide code has no effect on `sys_clk`, which keeps the slow clock period.
- R4: A write to the power-control word changes nothing unless the key register (address 1) holds 0x96.
- R5: Bit 2 of the power-control word selects the source: 1 selects the divided fast clock and 0 selects the slow clock.
- R6: A write to bit 2 is accepted only when the fast enable (bit 1) and the slow enable (bit 0) both already read 1; otherwise bit 2 keeps its old value.
- R7: A write to bit 2 is also rejected when the stable flag of the requested source is 0.
- R8: Writing 0 to the fast enable bit is ignored while bit 2 is 1, and bit 2 can never read 1 while the fast enable reads 0.
- R9: `sys_clk` never shows a high or low phase shorter than half a `fout` period, and the two sources are never gated onto the output at the same time.
- R10: A new divide code is applied only at the wrap point of the divide-by-8 counter.
- R11: The key register reads back its last written value and is not changed by writes to the power-control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register bus clock |
| rst_n | input | 1 | Synchronous active-low reset, held over several edges of every clock |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | Register select: 0 power-control word, 1 key register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the selected register |
| fout | input | 1 | Fast PLL output clock |
| lclk | input | 1 | Slow clock |
| hosc_stable | input | 1 | Fast oscillator stable flag |
| losc_stable | input | 1 | Slow oscillator stable flag |
| hosc_en | output | 1 | Fast oscillator enable |
| losc_en | output | 1 | Slow oscillator enable |
| sys_clk | output | 1 | Selected and divided system clock |

## Verification
A wrong register bit shows at `rdata` in the cycle after the write. It also shows as a wrong `sys_clk` period once the synchronisers settle: a few `fout` edges for a divide change, and a few edges of each clock for a source change. A broken handover or an unaligned divide change shows as a `sys_clk` phase shorter than half a `fout` period. Such a phase is caught by a pulse-width monitor that runs over the whole sequence. A wrong enable bit appears directly on the oscillator enable outputs.

// File: rtl/sysclk_ctrl_pkg.sv
// Package: shared register layout and key for the system clock controller.
// Assumes an 8-bit register bus with two registers.
package sysclk_ctrl_pkg;
    localparam int DATA_W    = 8;
    localparam int DIV_W     = 2;
    localparam int DIV_LSB   = 6;
    localparam int SRC_BIT   = 2;
    localparam int HEN_BIT   = 1;
    localparam int LEN_BIT   = 0;
    localparam logic PWR_ADDR = 1'b0;
    localparam logic KEY_ADDR = 1'b1;
    localparam logic [DATA_W-1:0] UNLOCK_KEY = 8'h96;
endpackage

// File: rtl/sysclk_ctrl_regs.sv
// Module: key-protected power-control register.
// Holds the divide code, the source select and both oscillator enables.
// Assumes the stable flags are already synchronous to clk.
module sysclk_ctrl_regs
    import sysclk_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              hosc_stable,
    input  logic              losc_stable,
    output logic [DATA_W-1:0] rdata,
    output logic [DIV_W-1:0]  div_code,
    output logic              src_high,
    output logic              hosc_en,
    output logic              losc_en
);
    logic [DATA_W-1:0] key_q;
    logic [DIV_W-1:0]  div_q;
    logic              src_q, hen_q, len_q;
    logic              unlocked, pwr_wr, src_ok, src_next;
    logic [DATA_W-1:0] pwr_word;

    // Decode write permission and the resulting source select.
    always_comb begin
        unlocked = (key_q == UNLOCK_KEY);
        pwr_wr   = wr_en && (addr == PWR_ADDR) && unlocked;
        src_ok   = hen_q && len_q &&
                   (wdata[SRC_BIT] ? hosc_stable : losc_stable);
        src_next = (pwr_wr && src_ok) ? wdata[SRC_BIT] : src_q;
    end

    // Register updates: key is always writable, power word only when unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_q <= '0;
            div_q <= '0;
            src_q <= 1'b1;
            hen_q <= 1'b1;
            len_q <= 1'b0;
        end else if (wr_en && (addr == KEY_ADDR)) begin
            key_q <= wdata;
        end else if (pwr_wr) begin
            div_q <= wdata[DIV_LSB +: DIV_W];
            len_q <= wdata[LEN_BIT];
            hen_q <= wdata[HEN_BIT] | src_q | src_next;
            src_q <= src_next;
        end
    end

    // Assemble the read view of the power-control word.
    always_comb begin
        pwr_word = '0;
        pwr_word[DIV_LSB +: DIV_W] = div_q;
        pwr_word[SRC_BIT] = src_q;
        pwr_word[HEN_BIT] = hen_q;
        pwr_word[LEN_BIT] = len_q;
        rdata = (addr == KEY_ADDR) ? key_q : pwr_word;
    end

    assign div_code = div_q;
    assign src_high = src_q;
    assign hosc_en  = hen_q;
    assign losc_en  = len_q;

    AST_LOCKED_DIV: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == PWR_ADDR && key_q != UNLOCK_KEY) |=> $stable(div_q)); // R4
    AST_SRC_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == PWR_ADDR && !(hen_q && len_q)) |=> $stable(src_q)); // R6
    AST_HOSC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        src_q |-> hen_q); // R8
    AST_KEY_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == PWR_ADDR) |=> $stable(key_q)); // R11
endmodule

// File: rtl/sysclk_ctrl_div.sv
// Module: fast clock divider with boundary-aligned ratio change.
// A free-running counter on fout supplies the divided taps. The requested
// code crosses into the fout domain through a flop chain and is applied on a
// falling fout edge while the counter is zero, when every tap is low.
// Assumes the code is held for several fout periods after a change.
module sysclk_ctrl_div #(
    parameter int DIV_W       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             fout,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_req,
    output logic             hs_clk
);
    localparam int NTAP  = 2 ** DIV_W;
    localparam int CNT_W = NTAP - 1;

    logic [CNT_W-1:0] cnt;
    logic [DIV_W-1:0] sync_q [SYNC_STAGES];
    logic [DIV_W-1:0] act_div;
    logic [NTAP-1:0]  taps;

    // Free-running divide counter.
    always_ff @(posedge fout) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + 1'b1;
    end

    // Bring the requested code into the fout domain.
    always_ff @(posedge fout) begin
        if (!rst_n) begin
            for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
        end else begin
            sync_q[0] <= div_req;
            for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
        end
    end

    // Apply a new code only where all taps are low.
    always_ff @(negedge fout) begin
        if (!rst_n)         act_div <= '0;
        else if (cnt == '0) act_div <= sync_q[SYNC_STAGES-1];
    end

    assign taps[0] = fout;
    for (genvar t = 1; t < NTAP; t++) begin : g_tap
        assign taps[t] = cnt[t-1];
    end

    assign hs_clk = taps[act_div];

    AST_DIV_AT_BOUNDARY: assert property (@(negedge fout) disable iff (!rst_n)
        (act_div != $past(act_div)) |-> ($past(cnt) == '0)); // R10
endmodule

// File: rtl/sysclk_ctrl_gate.sv
// Module: one side of a glitch-free two-clock handover.
// Asks for its clock only while the other side is released; the request
// passes a falling-edge flop chain of its own clock, so the gate changes
// only while that clock is low.
module sysclk_ctrl_gate #(
    parameter int   STAGES      = 2,
    parameter logic ON_AT_RESET = 1'b0
) (
    input  logic clk_in,
    input  logic rst_n,
    input  logic want,
    input  logic other_on,
    output logic gate_on
);
    logic [STAGES-1:0] chain;

    // Falling-edge synchroniser of the gated request.
    always_ff @(negedge clk_in) begin
        if (!rst_n) chain <= {STAGES{ON_AT_RESET}};
        else        chain <= {chain[STAGES-2:0], want & ~other_on};
    end

    assign gate_on = chain[STAGES-1];
endmodule

// File: rtl/sysclk_ctrl.sv
// Module: top of the system clock controller.
// Combines the register, the fast divider and the two handover gates.
// Assumes rst_n is held low over several edges of clk, fout and lclk.
module sysclk_ctrl
    import sysclk_ctrl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              fout,
    input  logic              lclk,
    input  logic              hosc_stable,
    input  logic              losc_stable,
    output logic              hosc_en,
    output logic              losc_en,
    output logic              sys_clk
);
    logic [DIV_W-1:0] div_code;
    logic             src_high, hs_clk, h_on, l_on;

    sysclk_ctrl_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .hosc_stable(hosc_stable), .losc_stable(losc_stable), .rdata(rdata),
        .div_code(div_code), .src_high(src_high),
        .hosc_en(hosc_en), .losc_en(losc_en)
    );

    sysclk_ctrl_div #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_div (
        .fout(fout), .rst_n(rst_n), .div_req(div_code), .hs_clk(hs_clk)
    );

    sysclk_ctrl_gate #(.STAGES(SYNC_STAGES), .ON_AT_RESET(1'b1)) u_hgate (
        .clk_in(hs_clk), .rst_n(rst_n), .want(src_high),
        .other_on(l_on), .gate_on(h_on)
    );

    sysclk_ctrl_gate #(.STAGES(SYNC_STAGES), .ON_AT_RESET(1'b0)) u_lgate (
        .clk_in(lclk), .rst_n(rst_n), .want(~src_high),
        .other_on(h_on), .gate_on(l_on)
    );

    assign sys_clk = (hs_clk & h_on) | (lclk & l_on);

    AST_ONE_SOURCE: assert property (@(posedge fout) disable iff (!rst_n)
        $onehot0({h_on, l_on})); // R9
endmodule

// File: tb/sysclk_ctrl_test.sv
`timescale 1ns/1ps
module sysclk_ctrl_test;
    localparam real CLK_PERIOD  = 10.0;
    localparam real FOUT_PERIOD = 4.0;
    localparam real LCLK_PERIOD = 30.0;
    localparam int  NVEC = 14;

    // {addr, wdata, expected power word, expected sys_clk period in ns}
    localparam logic [24:0] VEC [NVEC] = '{
        {1'b1, 8'h96, 8'h06, 8'd4},
        {1'b0, 8'h46, 8'h46, 8'd8},
        {1'b0, 8'h86, 8'h86, 8'd16},
        {1'b0, 8'hC6, 8'hC6, 8'd32},
        {1'b0, 8'h02, 8'h06, 8'd4},
        {1'b0, 8'h07, 8'h07, 8'd4},
        {1'b0, 8'h43, 8'h43, 8'd30},
        {1'b0, 8'h01, 8'h01, 8'd30},
        {1'b0, 8'h07, 8'h03, 8'd30},
        {1'b0, 8'h07, 8'h07, 8'd4},
        {1'b0, 8'h05, 8'h07, 8'd4},
        {1'b0, 8'h06, 8'h06, 8'd4},
        {1'b1, 8'h00, 8'h06, 8'd4},
        {1'b0, 8'hC7, 8'h06, 8'd4}
    };

    logic clk = 0, fout = 0, lclk = 0;
    logic rst_n = 0, wr_en = 0, addr = 0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic hosc_stable = 1, losc_stable = 1;
    logic hosc_en, losc_en, sys_clk;

    int  n_checks = 0, n_fail = 0;
    bit  mon_on = 0;
    real last_edge = 0.0, min_phase = 1000.0;

    sysclk_ctrl uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .fout(fout), .lclk(lclk), .hosc_stable(hosc_stable),
        .losc_stable(losc_stable), .hosc_en(hosc_en), .losc_en(losc_en),
        .sys_clk(sys_clk)
    );

    always #(CLK_PERIOD/2)  clk  = ~clk;
    always #(FOUT_PERIOD/2) fout = ~fout;
    always #(LCLK_PERIOD/2) lclk = ~lclk;

    // Track the shortest sys_clk phase while monitoring is on (R9, R10).
    always @(sys_clk) begin
        if (mon_on && ($realtime - last_edge) > 0.001 && ($realtime - last_edge) < min_phase)
            min_phase = $realtime - last_edge;
        last_edge = $realtime;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic period(output int p);
        realtime t0;
        #600;
        @(posedge sys_clk); t0 = $realtime;
        @(posedge sys_clk); p = int'($realtime - t0);
    endtask

    task automatic do_reset();
        mon_on = 0;
        @(negedge clk); rst_n = 0;
        repeat (20) @(negedge clk);
        rst_n = 1;
        #200;
        last_edge = $realtime;
        mon_on = 1;
    endtask

    task automatic check_reset(input string when);
        logic [7:0] v;
        int p;
        rd(1'b0, v); check(v == 8'h06, {"R1 power word ", when}, v, 8'h06);
        rd(1'b1, v); check(v == 8'h00, {"R1 key ", when}, v, 8'h00);
        check(hosc_en == 1'b1 && losc_en == 1'b0, {"R1 enables ", when}, {hosc_en, losc_en}, 2'b10);
        period(p);   check(p == 4, {"R1 sys_clk period ", when}, p, 4);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #100000;
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int p;
        do_reset();
        check_reset("after power-up");

        // Table walk: R2 R3 R4 R5 R6 R8 behaviour by row.
        for (int i = 0; i < NVEC; i++) begin
            wr(VEC[i][24], VEC[i][23:16]);
            rd(1'b0, v);
            check(v == VEC[i][15:8], $sformatf("row %0d power word (R2/R3/R4/R5/R6/R8)", i), v, VEC[i][15:8]);
            check(hosc_en == VEC[i][9] && losc_en == VEC[i][8],
                  $sformatf("row %0d enable outputs (R8)", i), {hosc_en, losc_en}, VEC[i][9:8]);
            period(p);
            check(p == int'(VEC[i][7:0]), $sformatf("row %0d sys_clk period (R2/R3/R5)", i), p, VEC[i][7:0]);
        end

        // R11: key reads back, survives power-word writes.
        rd(1'b1, v); check(v == 8'h00, "R11 key after lock", v, 8'h00);
        wr(1'b1, 8'h96);
        wr(1'b0, 8'h07);
        rd(1'b1, v); check(v == 8'h96, "R11 key kept after power write", v, 8'h96);

        // R7: slow source not stable, switch rejected.
        losc_stable = 0;
        wr(1'b0, 8'h03);
        rd(1'b0, v); check(v == 8'h07, "R7 switch to unstable slow source", v, 8'h07);
        period(p);   check(p == 4, "R7 sys_clk stays fast", p, 4);

        // R7: fast source not stable, switch back rejected.
        losc_stable = 1;
        wr(1'b0, 8'h03);
        rd(1'b0, v); check(v == 8'h03, "R5 switch to slow source", v, 8'h03);
        hosc_stable = 0;
        wr(1'b0, 8'hC7);
        rd(1'b0, v); check(v == 8'hC3, "R7 switch to unstable fast source", v, 8'hC3);
        period(p);   check(p == 30, "R3 divide ignored on slow source", p, 30);
        hosc_stable = 1;

        // R1: reset in the middle of slow operation.
        do_reset();
        check_reset("after mid-run reset");

        // R9 R10: no short sys_clk phase over the whole run.
        check(min_phase >= FOUT_PERIOD/2 - 0.01, "R9 R10 shortest sys_clk phase",
              int'(min_phase * 1000), int'(FOUT_PERIOD * 500));

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule